// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Sequencer

This block lets a small processor run counted loops without spending any instruction on the loop branch. When the decoder meets a loop-start instruction it raises a start request. The request carries the iteration count, the address of the last instruction in the body and the address of the first one. The sequencer saves the enclosing loop's state on an internal stack, arms the new loop and then watches every fetch address. When the fetch reaches the last body instruction and passes remain, it issues a one-cycle redirect back to the body's first address. On the final pass it lets fetch fall through and restores the enclosing loop in a single step.

The saved state of each active loop takes two stack words. One holds the end address and the remaining count of the enclosing loop. The other holds the return address and a copy of the status register, whose bit 15 is the loop-active flag. Loops therefore nest until the stack runs out of room. Loop state lives only in registers and on the stack, so fetch may pause between any two body instructions (for example while an interrupt is serviced) without disturbing the loop. Two sticky error flags report a start that did not fit on the stack and a start whose end address collides with the enclosing loop's end address.

Top module: `hwl_loop_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, do_busy, loop_flag, redirect_valid, sr_we, err_overflow and err_nest are all 0.
- R2: With do_short high, only the low 12 bits of do_count form the count and the upper 4 bits are treated as zero, so do_count 0xF004 gives 4 passes.
- R3: An accepted start holds do_busy high for the two cycles after the request cycle. In the cycle that follows, loop_flag is 1 and sr_we pulses with sr_wdata equal to sr_cur with bit 15 set.
- R4: A fetch whose address equals the active end address, with a remaining count other than 1, decrements the count and produces redirect_valid in the next cycle, with redirect_pc equal to the start's do_ret_pc.
- R5: A fetch of the end address with a remaining count of 1 produces no redirect. Fetch falls through to the next address, loop_flag takes bit 15 of the status copy saved at that loop's start, and sr_we pulses with that bit in bit 15 of sr_wdata.
- R6: A count of N from 1 to 65535 runs the body exactly N times; a count of 0 runs it 65536 times.
- R7: When an inner loop exits, the enclosing loop's end address, remaining count and return address are in force again, and it completes its own passes.
- R8: A start request that arrives with fewer than two free stack words (at most seven nested loops with the default 15 words) is not started, leaves all loop state unchanged and sets err_overflow.
- R9: A start request made while a loop is active, whose end address equals that loop's end address, is not started, leaves loop state unchanged and sets err_nest.
- R10: Cycles with fetch_valid low, and fetches of any address other than the end address, change neither the count nor the loop state, and produce no redirect.
- R11: err_overflow and err_nest stay set once set and clear only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| do_req | input | 1 | Loop-start request, one cycle, only while do_busy is low |
| do_short | input | 1 | Count is a 12-bit short immediate |
| do_count | input | 16 | Iteration count (0 means 65536) |
| do_end | input | 16 | Address of the last instruction of the body |
| do_ret_pc | input | 16 | Address of the first instruction of the body |
| sr_cur | input | 16 | Current status register; bit 15 is the loop flag |
| fetch_valid | input | 1 | A fetch takes place this cycle |
| fetch_pc | input | 16 | Address being fetched |
| do_busy | output | 1 | Start sequence in progress |
| redirect_valid | output | 1 | Take next fetch from redirect_pc |
| redirect_pc | output | 16 | Loop-top address |
| loop_flag | output | 1 | A hardware loop is active |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 16 | Status register write value |
| err_overflow | output | 1 | Sticky: start refused, stack full |
| err_nest | output | 1 | Sticky: start refused, shared end address |

## Verification
The assertions assume that do_req arrives only while do_busy is low. They also assume that fetch_valid is low while do_busy is high and in the same cycle as do_req, so that a stack push and a pop never meet. The stimulus follows from a small fetch program in the bench: a loop-start slot drops fetch_valid, raises do_req for one cycle and waits for do_busy to fall. The next fetch address follows redirect_pc only in the cycle after a fetch. Fetch pauses are inserted only between whole fetches, never between a fetch and the redirect it may produce.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PUSH2 = 2'd1,
    SQ_ARM   = 2'd2
  } seq_t;
endpackage

// File: rtl/hwl_stack.sv
module hwl_stack #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int DEPTH    = 15,
  parameter int FLAG_BIT = 15,
  localparam int SPW     = $clog2(DEPTH + 1),
  localparam int EW      = AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_hi,
  input  logic [DW-1:0] push_lo,
  input  logic          pop2,
  output logic          room2,
  output logic [AW-1:0] top_hi,
  output logic          top_flag,
  output logic [AW-1:0] below_hi,
  output logic [DW-1:0] below_lo
);
  logic [EW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] top_idx;
  logic [SPW-1:0] below_idx;

  // storage has no reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= {push_hi, push_lo};
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + SPW'(1);
    else if (pop2) sp <= sp - SPW'(2);
  end

  always_comb begin
    top_idx   = (sp == '0) ? '0 : sp - SPW'(1);
    below_idx = (sp < SPW'(2)) ? '0 : sp - SPW'(2);
  end

  assign room2    = (sp <= SPW'(DEPTH - 2));
  assign top_hi   = mem[top_idx][EW-1:DW];
  assign top_flag = mem[top_idx][FLAG_BIT];
  assign below_hi = mem[below_idx][EW-1:DW];
  assign below_lo = mem[below_idx][DW-1:0];

  // R8
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (sp < SPW'(DEPTH)));
  // R7
  pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
    pop2 |-> (sp >= SPW'(2)));
  // R7
  pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && pop2));
endmodule

// File: rtl/hwl_do_seq.sv
module hwl_do_seq
  import hwl_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int SHORT_W  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_req,
  input  logic          do_short,
  input  logic [DW-1:0] do_count,
  input  logic [AW-1:0] do_end,
  input  logic [AW-1:0] do_ret_pc,
  input  logic [DW-1:0] sr_cur,
  input  logic          lf,
  input  logic [AW-1:0] la,
  input  logic [DW-1:0] lc,
  input  logic          room2,
  output logic          busy,
  output logic          push,
  output logic [AW-1:0] push_hi,
  output logic [DW-1:0] push_lo,
  output logic          arm,
  output logic [AW-1:0] arm_la,
  output logic [DW-1:0] arm_lc,
  output logic          err_ovf,
  output logic          err_nest
);
  seq_t          state;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] end_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_sel;
  logic          is_idle;
  logic          nest_bad;
  logic          accept;

  always_comb begin
    if (do_short) cnt_sel = {{(DW-SHORT_W){1'b0}}, do_count[SHORT_W-1:0]};
    else          cnt_sel = do_count;
  end

  assign is_idle  = (state == SQ_IDLE);
  assign nest_bad = lf && (do_end == la);
  assign accept   = do_req && is_idle && !nest_bad && room2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      ret_q    <= '0;
      end_q    <= '0;
      cnt_q    <= '0;
      err_ovf  <= 1'b0;
      err_nest <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (do_req) begin
            if (nest_bad)    err_nest <= 1'b1;
            else if (!room2) err_ovf  <= 1'b1;
            else begin
              ret_q <= do_ret_pc;
              end_q <= do_end;
              cnt_q <= cnt_sel;
              state <= SQ_PUSH2;
            end
          end
        end
        SQ_PUSH2: state <= SQ_ARM;
        SQ_ARM:   state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    push    = 1'b0;
    push_hi = la;
    push_lo = lc;
    if (accept) begin
      push = 1'b1;
    end else if (state == SQ_PUSH2) begin
      push    = 1'b1;
      push_hi = ret_q;
      push_lo = sr_cur;
    end
  end

  assign busy   = !is_idle;
  assign arm    = (state == SQ_ARM);
  assign arm_la = end_q;
  assign arm_lc = cnt_q;

  // R3
  seq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_PUSH2) |=> (state == SQ_ARM));
  // R3
  seq_start_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state == SQ_PUSH2));
  // R9
  nest_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (do_req && is_idle && nest_bad) |=> (is_idle && err_nest));
  // R8
  ovf_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (do_req && is_idle && !room2) |=> is_idle);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf);
  // R11
  nest_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_nest |=> err_nest);
endmodule

// File: rtl/hwl_loop_core.sv
module hwl_loop_core #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LF_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          busy,
  input  logic          arm,
  input  logic [AW-1:0] arm_la,
  input  logic [DW-1:0] arm_lc,
  input  logic [DW-1:0] sr_cur,
  input  logic [AW-1:0] top_hi,
  input  logic          top_flag,
  input  logic [AW-1:0] below_hi,
  input  logic [DW-1:0] below_lo,
  output logic [AW-1:0] la,
  output logic [DW-1:0] lc,
  output logic          lf,
  output logic          pop2,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          sr_we,
  output logic [DW-1:0] sr_wdata
);
  logic          hit;
  logic          last;
  logic [DW-1:0] sr_set;
  logic [DW-1:0] sr_rest;

  assign hit  = fetch_valid && !busy && !arm && lf && (fetch_pc == la);
  assign last = (lc == DW'(1));
  assign pop2 = hit && last;

  always_comb begin
    sr_set          = sr_cur;
    sr_set[LF_BIT]  = 1'b1;
    sr_rest         = sr_cur;
    sr_rest[LF_BIT] = top_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      la             <= '0;
      lc             <= '0;
      lf             <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      sr_we          <= 1'b0;
      sr_wdata       <= '0;
    end else begin
      redirect_valid <= 1'b0;
      sr_we          <= 1'b0;
      if (arm) begin
        la       <= arm_la;
        lc       <= arm_lc;
        lf       <= 1'b1;
        sr_we    <= 1'b1;
        sr_wdata <= sr_set;
      end else if (hit) begin
        if (!last) begin
          lc             <= lc - DW'(1);
          redirect_valid <= 1'b1;
          redirect_pc    <= top_hi;
        end else begin
          la       <= below_hi;
          lc       <= below_lo;
          lf       <= top_flag;
          sr_we    <= 1'b1;
          sr_wdata <= sr_rest;
        end
      end
    end
  end

  // R4
  redirect_src_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> ($past(fetch_valid) && $past(lf)));
  // R5
  exit_noredir_chk: assert property (@(posedge clk) disable iff (rst)
    pop2 |=> (!redirect_valid && sr_we));
  // R3
  arm_flag_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (lf && sr_we && sr_wdata[LF_BIT]));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !arm) |=> ($stable(lc) && $stable(la) && $stable(lf) && !redirect_valid));
endmodule

// File: rtl/hwl_loop_ctrl.sv
module hwl_loop_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int DEPTH   = 15,
  parameter int SHORT_W = 12,
  parameter int LF_BIT  = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_req,
  input  logic          do_short,
  input  logic [DW-1:0] do_count,
  input  logic [AW-1:0] do_end,
  input  logic [AW-1:0] do_ret_pc,
  input  logic [DW-1:0] sr_cur,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          do_busy,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          loop_flag,
  output logic          sr_we,
  output logic [DW-1:0] sr_wdata,
  output logic          err_overflow,
  output logic          err_nest
);
  logic          busy;
  logic          push;
  logic [AW-1:0] push_hi;
  logic [DW-1:0] push_lo;
  logic          pop2;
  logic          room2;
  logic [AW-1:0] top_hi;
  logic          top_flag;
  logic [AW-1:0] below_hi;
  logic [DW-1:0] below_lo;
  logic          arm;
  logic [AW-1:0] arm_la;
  logic [DW-1:0] arm_lc;
  logic [AW-1:0] la;
  logic [DW-1:0] lc;
  logic          lf;

  hwl_stack #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .FLAG_BIT(LF_BIT)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_hi  (push_hi),
    .push_lo  (push_lo),
    .pop2     (pop2),
    .room2    (room2),
    .top_hi   (top_hi),
    .top_flag (top_flag),
    .below_hi (below_hi),
    .below_lo (below_lo)
  );

  hwl_do_seq #(
    .AW(AW), .DW(DW), .SHORT_W(SHORT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .do_req    (do_req),
    .do_short  (do_short),
    .do_count  (do_count),
    .do_end    (do_end),
    .do_ret_pc (do_ret_pc),
    .sr_cur    (sr_cur),
    .lf        (lf),
    .la        (la),
    .lc        (lc),
    .room2     (room2),
    .busy      (busy),
    .push      (push),
    .push_hi   (push_hi),
    .push_lo   (push_lo),
    .arm       (arm),
    .arm_la    (arm_la),
    .arm_lc    (arm_lc),
    .err_ovf   (err_overflow),
    .err_nest  (err_nest)
  );

  hwl_loop_core #(
    .AW(AW), .DW(DW), .LF_BIT(LF_BIT)
  ) u_core (
    .clk            (clk),
    .rst            (rst),
    .fetch_valid    (fetch_valid),
    .fetch_pc       (fetch_pc),
    .busy           (busy),
    .arm            (arm),
    .arm_la         (arm_la),
    .arm_lc         (arm_lc),
    .sr_cur         (sr_cur),
    .top_hi         (top_hi),
    .top_flag       (top_flag),
    .below_hi       (below_hi),
    .below_lo       (below_lo),
    .la             (la),
    .lc             (lc),
    .lf             (lf),
    .pop2           (pop2),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .sr_we          (sr_we),
    .sr_wdata       (sr_wdata)
  );

  assign do_busy   = busy;
  assign loop_flag = lf;

  // R10
  no_fetch_in_setup_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !redirect_valid);
endmodule

// File: tb/hwl_loop_ctrl_bench.sv
module hwl_loop_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        do_req = 1'b0;
  logic        do_short = 1'b0;
  logic [15:0] do_count = '0;
  logic [15:0] do_end = '0;
  logic [15:0] do_ret_pc = '0;
  logic [15:0] sr_cur = 16'h0234;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        do_busy;
  logic        redirect_valid;
  logic [15:0] redirect_pc;
  logic        loop_flag;
  logic        sr_we;
  logic [15:0] sr_wdata;
  logic        err_overflow;
  logic        err_nest;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  hwl_loop_ctrl u_hwl_loop_ctrl (
    .clk(clk), .rst(rst), .do_req(do_req), .do_short(do_short),
    .do_count(do_count), .do_end(do_end), .do_ret_pc(do_ret_pc),
    .sr_cur(sr_cur), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .do_busy(do_busy), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .loop_flag(loop_flag), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .err_overflow(err_overflow), .err_nest(err_nest)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] q[$];
  bit          m_lf, m_rv, m_we, m_ovf, m_nest;
  logic [15:0] m_la, m_lc, m_rpc, m_wd;
  int          m_phase;
  logic [15:0] p_ret, p_end, p_cnt;

  always @(posedge clk) begin
    m_rv = 1'b0;
    m_we = 1'b0;
    if (rst) begin
      q.delete();
      m_lf = 0; m_ovf = 0; m_nest = 0; m_phase = 0;
      m_la = '0; m_lc = '0; m_rpc = '0; m_wd = '0;
    end else if (m_phase == 2) begin
      m_lf = 1; m_la = p_end; m_lc = p_cnt;
      m_we = 1; m_wd = sr_cur | 16'h8000; m_phase = 0;
    end else if (m_phase == 1) begin
      q.push_back({p_ret, sr_cur});
      m_phase = 2;
    end else if (do_req) begin
      if (m_lf && do_end == m_la) m_nest = 1;
      else if (q.size() > 13) m_ovf = 1;
      else begin
        q.push_back({m_la, m_lc});
        p_ret = do_ret_pc; p_end = do_end;
        p_cnt = do_short ? {4'h0, do_count[11:0]} : do_count;
        m_phase = 1;
      end
    end else if (fetch_valid && m_lf && fetch_pc == m_la) begin
      if (m_lc != 16'd1) begin
        m_lc = m_lc - 16'd1;
        m_rv = 1;
        m_rpc = q[q.size()-1][31:16];
      end else begin
        logic        fl;
        logic [31:0] lower;
        fl = q[q.size()-1][15];
        lower = q[q.size()-2];
        m_la = lower[31:16];
        m_lc = lower[15:0];
        void'(q.pop_back());
        void'(q.pop_back());
        m_lf = fl;
        m_we = 1;
        m_wd = {fl, sr_cur[14:0]};
      end
    end
  end

  // processor status register follows the write port
  always @(negedge clk) begin
    if (rst) sr_cur = 16'h0234;
    else if (sr_we) sr_cur = sr_wdata;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(do_busy == (m_phase != 0), "R3 busy", do_busy, m_phase != 0);
      chk(loop_flag == m_lf, "R5 loop_flag", loop_flag, m_lf);
      chk(redirect_valid == m_rv, "R4 redirect_valid", redirect_valid, m_rv);
      if (m_rv) chk(redirect_pc == m_rpc, "R4 redirect_pc", redirect_pc, m_rpc);
      chk(sr_we == m_we, "R3/R5 sr_we", sr_we, m_we);
      if (m_we) chk(sr_wdata == m_wd, "R3/R5 sr_wdata", sr_wdata, m_wd);
      chk(err_overflow == m_ovf, "R8 err_overflow", err_overflow, m_ovf);
      chk(err_nest == m_nest, "R9 err_nest", err_nest, m_nest);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // fetch program
  int dt_cnt[int];
  int dt_end[int];
  int dt_short[int];
  int hits[int];

  task automatic run_prog(input int start, input int stop, input int stall_mod);
    int pc = start;
    int guard = 0;
    while (pc != stop && guard < 180000) begin
      guard++;
      if (dt_cnt.exists(pc)) begin
        do_req = 1; do_count = 16'(dt_cnt[pc]); do_short = dt_short[pc][0];
        do_end = 16'(dt_end[pc]); do_ret_pc = 16'(pc + 1); fetch_valid = 0;
        @(negedge clk);
        do_req = 0;
        while (do_busy) @(negedge clk);
        pc = pc + 1;
      end else if (stall_mod != 0 && ($urandom % stall_mod) == 0) begin
        fetch_valid = 0;
        @(negedge clk);
      end else begin
        fetch_valid = 1; fetch_pc = 16'(pc);
        if (!hits.exists(pc)) hits[pc] = 0;
        hits[pc]++;
        @(negedge clk);
        fetch_valid = 0;
        pc = redirect_valid ? int'(redirect_pc) : pc + 1;
      end
    end
    fetch_valid = 0;
  endtask

  function automatic int hit_of(input int pc);
    return hits.exists(pc) ? hits[pc] : 0;
  endfunction

  task automatic clear_prog();
    dt_cnt.delete(); dt_end.delete(); dt_short.delete(); hits.delete();
  endtask

  task automatic add_do(input int at, input int cnt, input int endp, input int sh);
    dt_cnt[at] = cnt; dt_end[at] = endp; dt_short[at] = sh;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    // R1 outputs held low during reset
    chk({do_busy, loop_flag, redirect_valid, sr_we, err_overflow, err_nest} == 6'b0,
        "R1 in reset", int'({do_busy, loop_flag, redirect_valid, sr_we, err_overflow, err_nest}), 0);
    rst = 0;
    @(negedge clk);
    chk({do_busy, loop_flag, redirect_valid, sr_we, err_overflow, err_nest} == 6'b0,
        "R1 after reset", int'({do_busy, loop_flag, redirect_valid, sr_we, err_overflow, err_nest}), 0);
  endtask

  initial begin
    do_reset();

    // R4 R6 simple loop of three passes
    clear_prog(); add_do(16'h10, 3, 16'h13, 0);
    run_prog(16'h10, 16'h14, 0);
    chk(hit_of(16'h11) == 3, "R6 three passes", hit_of(16'h11), 3);
    chk(hit_of(16'h13) == 3, "R4 end fetched each pass", hit_of(16'h13), 3);
    chk(loop_flag == 0, "R5 flag cleared on exit", loop_flag, 0);

    // R2 short immediate ignores upper count bits
    clear_prog(); add_do(16'h20, 16'hF004, 16'h22, 1);
    run_prog(16'h20, 16'h23, 0);
    chk(hit_of(16'h21) == 4, "R2 short count", hit_of(16'h21), 4);

    // R7 nested loops
    clear_prog(); add_do(16'h30, 3, 16'h36, 0); add_do(16'h31, 2, 16'h34, 0);
    run_prog(16'h30, 16'h37, 0);
    chk(hit_of(16'h32) == 6, "R7 inner body", hit_of(16'h32), 6);
    chk(hit_of(16'h35) == 3, "R7 outer tail", hit_of(16'h35), 3);
    chk(loop_flag == 0, "R7 all loops closed", loop_flag, 0);

    // R10 fetch pauses do not disturb nested loops
    clear_prog(); add_do(16'h30, 3, 16'h36, 0); add_do(16'h31, 2, 16'h34, 0);
    run_prog(16'h30, 16'h37, 3);
    chk(hit_of(16'h32) == 6, "R10 inner body with stalls", hit_of(16'h32), 6);
    chk(hit_of(16'h36) == 3, "R10 outer end with stalls", hit_of(16'h36), 3);

    // R9 colliding end address is refused
    clear_prog(); add_do(16'h40, 2, 16'h46, 0); add_do(16'h41, 5, 16'h46, 0);
    run_prog(16'h40, 16'h47, 0);
    chk(err_nest == 1, "R9 flag set", err_nest, 1);
    chk(hit_of(16'h42) == 2, "R9 outer unaffected", hit_of(16'h42), 2);
    repeat (4) @(negedge clk);
    chk(err_nest == 1, "R11 nest flag sticky", err_nest, 1);
    do_reset();
    chk(err_nest == 0, "R11 reset clears", err_nest, 0);

    // R8 eighth nested loop does not fit
    clear_prog();
    for (int k = 0; k < 8; k++) add_do(16'h50 + k, 1, 16'h6F - k, 0);
    run_prog(16'h50, 16'h70, 0);
    chk(err_overflow == 1, "R8 overflow flagged", err_overflow, 1);
    chk(hit_of(16'h58) == 1, "R8 body runs once", hit_of(16'h58), 1);
    chk(hit_of(16'h6F) == 1, "R8 outermost exit", hit_of(16'h6F), 1);
    chk(loop_flag == 0, "R8 loops unwound", loop_flag, 0);
    repeat (3) @(negedge clk);
    chk(err_overflow == 1, "R11 overflow sticky", err_overflow, 1);

    // R6 count zero gives 65536 passes
    clear_prog(); add_do(16'h80, 0, 16'h81, 0);
    run_prog(16'h80, 16'h82, 0);
    chk(hit_of(16'h81) == 65536, "R6 zero count", hit_of(16'h81), 65536);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule